// File: doc/BRIEF.md
# Maskable Interrupt Unit with Priority Chain

This block gathers eight interrupt events into a sticky status register, qualifies them with a software mask, and signals a shared active-low request line. Software reads both the raw and the masked status, and it clears status bits by writing ones. One of the eight status bits comes from a line-break detector rather than an event input. That bit latches whenever the break line changes level in either direction.

Several copies of the block share one request line through a priority chain. Each device may request only while its chain enable input is high. It holds its chain enable output low while it has a pending or in-service interrupt, and this keeps devices further down the chain quiet. When the host runs an acknowledge cycle, the eligible device drives its stored vector byte onto the data bus and enters service. It leaves service when the host pulses the return strobe.

Top module: `irq_chain_ctrl`

## Requirements
- R1: A status bit sets in the clock edge after its event input is high and stays set until software writes a 1 to that bit at register address 0. If a set and a clear hit the same bit in the same cycle, the set wins.
- R2: The mask register at address 2 reads back what was written, and a 1 enables that source. Address 1 reads the raw status ANDed with the mask, and address 0 reads the raw status.
- R3: `irq_n` is low exactly when at least one masked status bit is 1 and `ien_in` is high.
- R4: Status bit 6 sets on every rising or falling transition of `rx_break`. Event input bit 6 has no effect on status.
- R5: `ien_out` equals `ien_in` while nothing is pending and the device is not in service. It is low while any masked bit is pending or the device is in service.
- R6: While `iack_n` is low, `ien_in` is high and a masked bit is pending, `vec_oe` is high and `vec_data` carries the vector register at address 3. The device is in service from the next clock edge.
- R7: An acknowledge that arrives while `ien_in` is low or nothing is pending leaves `vec_oe` low and does not put the device in service.
- R8: A one-cycle pulse on `rti` ends service. If the pulse coincides with an acceptable acknowledge, the device ends up out of service.
- R9: After reset, status and mask are 0 and the vector is 0x0F. `irq_n` is high, `vec_oe` is low and `ien_out` follows `ien_in`.
- R10: Writes to address 1 change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | 8 | Interrupt event inputs, level or pulse, one per status bit |
| rx_break | input | 1 | Receiver break line level; each transition sets status bit 6 |
| cpu_sel | input | 1 | Register access select |
| cpu_wr | input | 1 | Write when high, read when low |
| cpu_addr | input | 2 | 0 raw status / clear, 1 masked status, 2 mask, 3 vector |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register |
| ien_in | input | 1 | Chain enable from the higher-priority neighbour |
| ien_out | output | 1 | Chain enable to the lower-priority neighbour |
| irq_n | output | 1 | Active-low interrupt request |
| iack_n | input | 1 | Active-low interrupt acknowledge |
| rti | input | 1 | Return-from-interrupt strobe |
| vec_oe | output | 1 | Data bus drive enable during acknowledge (low means high impedance) |
| vec_data | output | 8 | Vector byte driven during acknowledge |

## Verification
The properties assume that all inputs are synchronous to the clock and that reset is held low for the first edges. They also assume that a register write lasts one cycle and that `rti` is a single-cycle pulse. The stimulus changes every input on the falling clock edge and holds each access for exactly one cycle. This keeps every event, acknowledge and return strobe inside those assumptions, while still placing a clear and a set in the same cycle and an acknowledge together with a low chain enable.

// File: rtl/irq_chain_pkg.sv
// Shared register address encoding for the interrupt unit.
package irq_chain_pkg;
    typedef enum logic [1:0] {
        REG_RAW  = 2'd0,   // raw status read, write-1-to-clear
        REG_MSKD = 2'd1,   // masked status, read only
        REG_MASK = 2'd2,   // source enable mask
        REG_VEC  = 2'd3    // acknowledge vector byte
    } irq_reg_e;
endpackage

// File: rtl/irq_src_latch.sv
// Sticky status register. Each bit latches its event input. The break bit
// instead latches on any level change of the break line.
// Assumes: all inputs synchronous to clk; a set wins over a same-cycle clear.
module irq_src_latch #(
    parameter int NSRC    = 8,
    parameter int BRK_BIT = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_evt,
    input  logic            rx_break,
    input  logic            clr_en,
    input  logic [NSRC-1:0] clr_bits,
    output logic [NSRC-1:0] status
);
    logic            brk_q;
    logic            brk_edge;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;

    // Remember the previous break level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_q <= 1'b0;
        else        brk_q <= rx_break;
    end

    assign brk_edge = rx_break ^ brk_q;
    assign clr_vec  = clr_en ? clr_bits : '0;

    // Substitute the break transition for the event input at BRK_BIT.
    always_comb begin
        set_vec          = src_evt;
        set_vec[BRK_BIT] = brk_edge;
    end

    // Sticky status: set dominates clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end
endmodule

// File: rtl/irq_regs.sv
// Software-visible register file: mask and vector storage, status clear
// decode and the read multiplexer.
// Assumes: single-cycle accesses; reads are combinational from the address.
module irq_regs
    import irq_chain_pkg::*;
#(
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  VEC_RST = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] vector,
    output logic              clr_en,
    output logic [DATA_W-1:0] clr_bits
);
    irq_reg_e reg_sel;
    logic     wr_go;

    assign reg_sel  = irq_reg_e'(cpu_addr);
    assign wr_go    = cpu_sel & cpu_wr;
    assign clr_en   = wr_go && (reg_sel == REG_RAW);
    assign clr_bits = cpu_wdata;

    // Mask and vector storage; the masked-status address is read only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask   <= '0;
            vector <= VEC_RST[DATA_W-1:0];
        end else if (wr_go) begin
            if (reg_sel == REG_MASK) mask   <= cpu_wdata;
            if (reg_sel == REG_VEC)  vector <= cpu_wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        unique case (reg_sel)
            REG_RAW:  cpu_rdata = status;
            REG_MSKD: cpu_rdata = status & mask;
            REG_MASK: cpu_rdata = mask;
            REG_VEC:  cpu_rdata = vector;
            default:  cpu_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_chain_link.sv
// Priority chain stage: request gating, enable pass-through, acknowledge
// vector drive and the in-service flag.
// Assumes: rti is a one-cycle strobe and takes priority over a same-cycle ack.
module irq_chain_link #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending,
    input  logic              ien_in,
    input  logic              iack_n,
    input  logic              rti,
    input  logic [DATA_W-1:0] vector,
    output logic              irq_n,
    output logic              ien_out,
    output logic              vec_oe,
    output logic [DATA_W-1:0] vec_data,
    output logic              in_svc
);
    logic ack_ok;

    assign ack_ok   = ~iack_n & ien_in & pending;
    assign irq_n    = ~(pending & ien_in);
    assign ien_out  = ien_in & ~pending & ~in_svc;
    assign vec_oe   = ack_ok;
    assign vec_data = ack_ok ? vector : '0;

    // In-service flag: entered on an accepted ack, left on the return strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      in_svc <= 1'b0;
        else if (rti)    in_svc <= 1'b0;
        else if (ack_ok) in_svc <= 1'b1;
    end
endmodule

// File: rtl/irq_chain_ctrl.sv
// Top level of the maskable interrupt unit with a priority chain.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module irq_chain_ctrl #(
    parameter int         DATA_W  = 8,
    parameter int         BRK_BIT = 6,
    parameter logic [7:0] VEC_RST = 8'h0F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_evt,
    input  logic              rx_break,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [1:0]        cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              ien_in,
    output logic              ien_out,
    output logic              irq_n,
    input  logic              iack_n,
    input  logic              rti,
    output logic              vec_oe,
    output logic [DATA_W-1:0] vec_data
);
    localparam int NSRC = DATA_W;

    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] vector_q;
    logic [NSRC-1:0] clr_bits;
    logic            clr_en;
    logic            pending;
    logic            in_svc;

    assign pending = |(status_q & mask_q);

    irq_src_latch #(.NSRC(NSRC), .BRK_BIT(BRK_BIT)) u_latch (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .rx_break(rx_break),
        .clr_en(clr_en), .clr_bits(clr_bits), .status(status_q)
    );

    irq_regs #(.DATA_W(DATA_W), .VEC_RST(VEC_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .status(status_q),
        .cpu_rdata(cpu_rdata), .mask(mask_q), .vector(vector_q),
        .clr_en(clr_en), .clr_bits(clr_bits)
    );

    irq_chain_link #(.DATA_W(DATA_W)) u_link (
        .clk(clk), .rst_n(rst_n), .pending(pending), .ien_in(ien_in),
        .iack_n(iack_n), .rti(rti), .vector(vector_q), .irq_n(irq_n),
        .ien_out(ien_out), .vec_oe(vec_oe), .vec_data(vec_data),
        .in_svc(in_svc)
    );
endmodule

// File: rtl/irq_chain_chk.sv
// Property checker for irq_chain_ctrl, attached through bind.
module irq_chain_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_n,
    input logic              ien_in,
    input logic              ien_out,
    input logic              vec_oe,
    input logic [DATA_W-1:0] vec_data,
    input logic [DATA_W-1:0] vector,
    input logic [DATA_W-1:0] status,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic [1:0]        cpu_addr,
    input logic              rti,
    input logic              in_svc
);
    logic wr_raw;
    assign wr_raw = cpu_sel & cpu_wr & (cpu_addr == 2'd0);

    // R1: a status bit only falls after a clear write.
    assert_sticky_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(status) & ~status) != '0) |-> $past(wr_raw));

    // R3: no request without the chain enable.
    assert_req_needs_ien_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ien_in);

    // R5: a requesting device blocks the chain.
    assert_chain_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n || in_svc) |-> !ien_out);

    // R6: the driven vector is the stored one and service follows.
    assert_vec_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_oe |-> (vec_data == vector));
    assert_enter_svc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_oe && !rti) |=> in_svc);

    // R7: no bus drive without the chain enable.
    assert_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_in |-> !vec_oe);

    // R8: return strobe ends service.
    assert_rti_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rti |=> !in_svc);
endmodule

bind irq_chain_ctrl irq_chain_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .ien_in(ien_in),
    .ien_out(ien_out), .vec_oe(vec_oe), .vec_data(vec_data),
    .vector(vector_q), .status(status_q), .cpu_sel(cpu_sel),
    .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .rti(rti), .in_svc(in_svc)
);

// File: tb/irq_chain_ctrl_tb.sv
module irq_chain_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_evt = '0;
    logic       rx_break = 1'b0;
    logic       cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       ien_in = 1'b1;
    logic       ien_out, irq_n, vec_oe;
    logic       iack_n = 1'b1, rti = 1'b0;
    logic [7:0] vec_data;

    int n_chk = 0, n_fail = 0;
    logic [7:0] rd;

    always #2 clk = ~clk;   // 250 MHz

    irq_chain_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .rx_break(rx_break),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ien_in(ien_in),
        .ien_out(ien_out), .irq_n(irq_n), .iack_n(iack_n), .rti(rti),
        .vec_oe(vec_oe), .vec_data(vec_data)
    );

    // Rows: {event, mask, expected raw, expected masked}; bit 6 events are ignored.
    localparam logic [31:0] TAB [6] = '{
        32'h01_01_01_01, 32'h81_80_81_80, 32'h3C_0F_3C_0C,
        32'h40_FF_00_00, 32'hFF_00_BF_00, 32'h12_12_12_12
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_sel = 0; cpu_wr = 0;
    endtask

    task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cpu_addr = a; #1 d = cpu_rdata;
    endtask

    task automatic pulse_src(input logic [7:0] v);
        @(negedge clk); src_evt = v;
        @(negedge clk); src_evt = '0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 0);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        #1;
        check("R9 irq_n", {7'd0, irq_n}, 8'd1);
        check("R9 vec_oe", {7'd0, vec_oe}, 8'd0);
        check("R9 ien_out", {7'd0, ien_out}, 8'd1);
        rdreg(2'd0, rd); check("R9 status", rd, 8'h00);
        rdreg(2'd2, rd); check("R9 mask", rd, 8'h00);
        rdreg(2'd3, rd); check("R9 vector", rd, 8'h0F);

        // Table walk: R1 R2 R3 R4
        for (int i = 0; i < 6; i++) begin
            logic [7:0] ev, mk, er, em;
            {ev, mk, er, em} = TAB[i];
            wr(2'd0, 8'hFF);
            wr(2'd2, mk);
            pulse_src(ev);
            rdreg(2'd0, rd); check("R1/R4 raw", rd, er);
            rdreg(2'd1, rd); check("R2 masked", rd, em);
            rdreg(2'd2, rd); check("R2 mask rb", rd, mk);
            check("R3 irq_n", {7'd0, irq_n}, (em != 0) ? 8'd0 : 8'd1);
        end

        // R1: status persists without clear, then set beats same-cycle clear
        wr(2'd0, 8'hFF); pulse_src(8'h04);
        repeat (3) @(negedge clk);
        rdreg(2'd0, rd); check("R1 sticky", rd, 8'h04);
        @(negedge clk); cpu_sel = 1; cpu_wr = 1; cpu_addr = 2'd0; cpu_wdata = 8'h0C; src_evt = 8'h08;
        @(negedge clk); cpu_sel = 0; cpu_wr = 0; src_evt = 0;
        rdreg(2'd0, rd); check("R1 set wins", rd, 8'h08);

        // R10: write to masked-status address is ignored
        wr(2'd2, 8'h3C);
        wr(2'd1, 8'hA5);
        rdreg(2'd2, rd); check("R10 mask kept", rd, 8'h3C);
        rdreg(2'd3, rd); check("R10 vector kept", rd, 8'h0F);
        rdreg(2'd0, rd); check("R10 status kept", rd, 8'h08);

        // R4: both break transitions set bit 6
        wr(2'd0, 8'hFF);
        @(negedge clk); rx_break = 1;
        @(negedge clk); rdreg(2'd0, rd); check("R4 break rise", rd, 8'h40);
        wr(2'd0, 8'hFF);
        rdreg(2'd0, rd); check("R4 cleared", rd, 8'h00);
        @(negedge clk); rx_break = 0;
        @(negedge clk); rdreg(2'd0, rd); check("R4 break fall", rd, 8'h40);
        wr(2'd0, 8'hFF);

        // R5 R6 R8: request, acknowledge, service, return
        wr(2'd3, 8'hA5);
        wr(2'd2, 8'h01);
        @(negedge clk); #1 check("R5 idle ien_out", {7'd0, ien_out}, 8'd1);
        pulse_src(8'h01);
        #1 check("R3 request", {7'd0, irq_n}, 8'd0);
        check("R5 blocked", {7'd0, ien_out}, 8'd0);
        @(negedge clk); iack_n = 0; #1;
        check("R6 vec_oe", {7'd0, vec_oe}, 8'd1);
        check("R6 vec_data", vec_data, 8'hA5);
        @(negedge clk); iack_n = 1;
        wr(2'd0, 8'hFF);
        #1 check("R3 released", {7'd0, irq_n}, 8'd1);
        check("R5 in service", {7'd0, ien_out}, 8'd0);
        @(negedge clk); rti = 1;
        @(negedge clk); rti = 0; #1;
        check("R8 service ended", {7'd0, ien_out}, 8'd1);

        // R8: return strobe together with an accepted ack leaves device idle
        pulse_src(8'h01);
        @(negedge clk); iack_n = 0; rti = 1;
        @(negedge clk); iack_n = 1; rti = 0;
        wr(2'd0, 8'hFF);
        #1 check("R8 rti wins", {7'd0, ien_out}, 8'd1);

        // R7: chain enable low blocks request and acknowledge
        ien_in = 0;
        pulse_src(8'h01);
        #1 check("R3 gated", {7'd0, irq_n}, 8'd1);
        check("R5 passes low", {7'd0, ien_out}, 8'd0);
        @(negedge clk); iack_n = 0; #1;
        check("R7 no drive", {7'd0, vec_oe}, 8'd0);
        @(negedge clk); iack_n = 1;
        wr(2'd0, 8'hFF);
        @(negedge clk); ien_in = 1; #1;
        check("R7 no service", {7'd0, ien_out}, 8'd1);

        // R7: acknowledge with nothing pending
        @(negedge clk); iack_n = 0; #1;
        check("R7 idle ack", {7'd0, vec_oe}, 8'd0);
        @(negedge clk); iack_n = 1; #1;
        check("R7 idle ack svc", {7'd0, ien_out}, 8'd1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule